// File: doc/BRIEF.md
# UART Receive Descriptor Engine

This block sits behind a UART receiver and moves each received character into memory buffers that software hands over through a circular table of descriptors. Each descriptor is four 16-bit words: a status/control word, a received byte count and a 32-bit byte pointer to the buffer, split into a high and a low word. Software marks a descriptor as empty to give it to the engine. The engine fills the buffer one byte at a time and closes it in one of two cases: the programmed maximum length is reached, or a character arrives with a framing or parity error. In the error case that character is the last byte of the buffer. On close the engine writes the byte count, then the status word with the ownership bit cleared and the error bits for that buffer. It then moves on to the next descriptor.

Overrun and loss of carrier do not close the buffer. They are recorded in the status of the buffer that is open when they happen. If the next descriptor is still owned by software, each incoming character is dropped and a busy event is raised. The status word is read again for every later character, so reception resumes as soon as software returns the descriptor.

The memory port is word-addressed and 16 bits wide, with a byte strobe per lane. Read data returns on the cycle after the request, and writes complete at once. Status bits are numbered MSB-first: status bit n is data bit 15-n.

Top module: `uart_rxdesc_engine`

## Requirements
- R1: After reset, no memory request is made and `buf_done` and `busy_evt` are low until a character arrives. The first descriptor used is the one at `tbl_base`.
- R2: On a character with no buffer open, the engine reads the status word (descriptor word 0). If the empty bit (status bit 0, data bit 15) is set, it reads the pointer high word (word 2) and low word (word 3), then stores the character.
- R3: Byte n of a buffer goes to byte address pointer+n, which is word (pointer+n)>>1. An even byte address uses the upper lane (strobe 2'b10) and an odd one uses the lower lane (strobe 2'b01). The other lane is left unchanged.
- R4: When the byte count reaches `max_len`, the buffer closes. The count is written to word 1, and on the next cycle the status word is written with the empty bit cleared.
- R5: A character flagged with a framing error is stored as the last byte of its buffer. The buffer closes with the framing bit (status bit 11, data bit 4) set.
- R6: A character flagged with a parity error is stored as the last byte of its buffer. The buffer closes with the parity bit (status bit 12, data bit 3) set.
- R7: After a buffer closes, the next character goes into the buffer of the next descriptor, four words further on.
- R8: The overrun bit (status bit 14, data bit 1) is set when `chr_overrun` pulses while a buffer is being claimed or filled. It is also set when a character arrives while an earlier one is still waiting, and that new character is lost. Neither case closes the buffer.
- R9: The carrier-lost bit (status bit 15, data bit 0) is set when `carrier_ok` falls while a buffer is being claimed or filled.
- R10: The closing status write keeps every bit that software wrote except the empty bit and bits 11 to 15. The reserved bit 13 (data bit 2) is written as zero, and error bits left over from software are replaced by the buffer's own.
- R11: A descriptor with the wrap bit (status bit 2, data bit 13) set is followed by the descriptor at `tbl_base`.
- R12: A descriptor with the interrupt bit (status bit 3, data bit 12) set produces a one-cycle `buf_done` pulse in the cycle of its status write. Other descriptors produce none.
- R13: A character that finds the current descriptor not empty is dropped. No memory write is made, `busy_evt` pulses once, and the descriptor index does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chr_valid | input | 1 | One-cycle strobe: a received character is present |
| chr_data | input | 8 | Received character |
| chr_frame_err | input | 1 | Character had no valid stop bit |
| chr_parity_err | input | 1 | Character failed its parity check |
| chr_overrun | input | 1 | Receiver overrun pulse |
| carrier_ok | input | 1 | High while carrier is present |
| tbl_base | input | AW | Word address of the first descriptor |
| max_len | input | 16 | Buffer length in bytes, nonzero |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_be | output | 2 | Lane strobes, bit 1 = upper byte |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |
| buf_done | output | 1 | Pulse on close of a buffer with the interrupt bit set |
| busy_evt | output | 1 | Pulse when a character is dropped |

## Verification
A plain run of four characters into an even-aligned buffer checks the normal path: byte packing, the length limit and a clean status. A buffer at an odd pointer over a pre-filled memory shows whether the lane strobes leave the neighbouring byte alone. Framing-error and parity-error characters each end a buffer early, and the wrap and interrupt bits on those descriptors show how the table index and `buf_done` respond. A descriptor still owned by software, then the same one handed back with stale error bits and spare control bits, separates a dropped character from a stored one and a preserved control bit from a replaced one. A further buffer sees an overrun pulse, a carrier drop, and a second character that arrives before the first has been taken.

// File: rtl/uart_rxdesc_pkg.sv
package uart_rxdesc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_STAT, ST_CHK, ST_PHI, ST_PLO, ST_FILL, ST_WCNT, ST_WSTAT
  } rxd_state_e;

  // status bit numbers, MSB-first (bit n lives at data[15-n])
  localparam int SB_EMPTY = 0;
  localparam int SB_WRAP  = 2;
  localparam int SB_INTR  = 3;
  localparam int SB_FR    = 11;
  localparam int SB_PR    = 12;
  localparam int SB_RSV   = 13;
  localparam int SB_OV    = 14;
  localparam int SB_CD    = 15;

  localparam int DESC_STRIDE = 4;

  typedef struct packed {
    logic fr;
    logic pr;
    logic ov;
    logic cd;
  } rx_err_t;

  // status word written back on close
  function automatic logic [15:0] close_status(input logic [15:0] orig, input rx_err_t e);
    logic [15:0] w;
    w = orig;
    w[15-SB_EMPTY] = 1'b0;
    w[15-SB_FR]    = e.fr;
    w[15-SB_PR]    = e.pr;
    w[15-SB_RSV]   = 1'b0;
    w[15-SB_OV]    = e.ov;
    w[15-SB_CD]    = e.cd;
    return w;
  endfunction

  // big-endian lane select: even byte address -> upper lane
  function automatic logic [1:0] lane_be(input logic odd);
    return odd ? 2'b01 : 2'b10;
  endfunction

endpackage

// File: rtl/uart_rxdesc_hold.sv
module uart_rxdesc_hold (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_fr,
  input  logic       in_pe,
  input  logic       pop,
  output logic       held,
  output logic [7:0] held_data,
  output logic       held_fr,
  output logic       held_pe,
  output logic       lost
);
  logic load;

  assign load = in_valid && (!held || pop);
  assign lost = in_valid && held && !pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held      <= 1'b0;
      held_data <= '0;
      held_fr   <= 1'b0;
      held_pe   <= 1'b0;
    end else if (load) begin
      held      <= 1'b1;
      held_data <= in_data;
      held_fr   <= in_fr;
      held_pe   <= in_pe;
    end else if (pop) begin
      held <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rxdesc_erracc.sv
module uart_rxdesc_erracc
  import uart_rxdesc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    track,
  input  logic    clear,
  input  logic    set_fr,
  input  logic    set_pr,
  input  logic    ovr_pulse,
  input  logic    lost,
  input  logic    carrier_ok,
  output rx_err_t err
);
  logic    carrier_q;
  logic    cd_fall;
  rx_err_t hit;

  assign cd_fall = carrier_q && !carrier_ok;

  always_comb begin
    hit.fr = set_fr;
    hit.pr = set_pr;
    hit.ov = lost || (track && ovr_pulse);
    hit.cd = track && cd_fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carrier_q <= 1'b1;
      err       <= '0;
    end else begin
      carrier_q <= carrier_ok;
      if (clear) err <= '0;
      else       err <= err | hit;
    end
  end
endmodule

// File: rtl/uart_rxdesc_engine.sv
module uart_rxdesc_engine
  import uart_rxdesc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chr_valid,
  input  logic [7:0]    chr_data,
  input  logic          chr_frame_err,
  input  logic          chr_parity_err,
  input  logic          chr_overrun,
  input  logic          carrier_ok,
  input  logic [AW-1:0] tbl_base,
  input  logic [15:0]   max_len,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_be,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          buf_done,
  output logic          busy_evt
);
  localparam logic [AW-1:0] STRIDE = AW'(DESC_STRIDE);

  rxd_state_e    state, state_nxt;
  logic [AW-1:0] desc_ofs;
  logic [AW-1:0] desc_addr;
  logic [15:0]   orig_stat;
  logic [31:0]   ptr;
  logic [15:0]   fill_cnt;
  logic [15:0]   cnt_nxt;
  logic [31:0]   byte_addr;

  logic       held, held_fr, held_pe, lost, pop;
  logic [7:0] held_data;
  rx_err_t    err;

  // named internal events
  logic ev_claim, ev_drop, ev_store, store_err, ev_close_now, ev_cnt_wr, ev_stat_wr;

  assign desc_addr = tbl_base + desc_ofs;
  assign byte_addr = ptr + {16'd0, fill_cnt};
  assign cnt_nxt   = fill_cnt + 16'd1;

  assign ev_claim     = (state == ST_CHK) && mem_rdata[15-SB_EMPTY];
  assign ev_drop      = (state == ST_CHK) && !mem_rdata[15-SB_EMPTY];
  assign ev_store     = (state == ST_FILL) && held;
  assign store_err    = held_fr || held_pe;
  assign ev_close_now = ev_store && (store_err || (cnt_nxt == max_len));
  assign ev_cnt_wr    = (state == ST_WCNT);
  assign ev_stat_wr   = (state == ST_WSTAT);
  assign pop          = ev_store || ev_drop;

  assign busy_evt = ev_drop;
  assign buf_done = ev_stat_wr && orig_stat[15-SB_INTR];

  uart_rxdesc_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (chr_valid),
    .in_data   (chr_data),
    .in_fr     (chr_frame_err),
    .in_pe     (chr_parity_err),
    .pop       (pop),
    .held      (held),
    .held_data (held_data),
    .held_fr   (held_fr),
    .held_pe   (held_pe),
    .lost      (lost)
  );

  uart_rxdesc_erracc u_err (
    .clk        (clk),
    .rst_n      (rst_n),
    .track      ((state != ST_IDLE) || held),
    .clear      (ev_stat_wr || ev_drop),
    .set_fr     (ev_store && held_fr),
    .set_pr     (ev_store && held_pe),
    .ovr_pulse  (chr_overrun),
    .lost       (lost),
    .carrier_ok (carrier_ok),
    .err        (err)
  );

  // memory port and next state
  always_comb begin
    state_nxt = state;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_be    = 2'b11;
    mem_wdata = '0;
    unique case (state)
      ST_IDLE:    if (held) state_nxt = ST_RD_STAT;
      ST_RD_STAT: begin
        mem_req   = 1'b1;
        state_nxt = ST_CHK;
      end
      ST_CHK: begin
        if (ev_claim) begin
          mem_req   = 1'b1;
          mem_addr  = desc_addr + AW'(2);
          state_nxt = ST_PHI;
        end else begin
          state_nxt = ST_IDLE;
        end
      end
      ST_PHI: begin
        mem_req   = 1'b1;
        mem_addr  = desc_addr + AW'(3);
        state_nxt = ST_PLO;
      end
      ST_PLO: state_nxt = ST_FILL;
      ST_FILL: begin
        if (held) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = byte_addr[AW:1];
          mem_be    = lane_be(byte_addr[0]);
          mem_wdata = {held_data, held_data};
          if (ev_close_now) state_nxt = ST_WCNT;
        end
      end
      ST_WCNT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr + AW'(1);
        mem_wdata = fill_cnt;
        state_nxt = ST_WSTAT;
      end
      ST_WSTAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = close_status(orig_stat, err);
        state_nxt = ST_IDLE;
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      desc_ofs  <= '0;
      orig_stat <= '0;
      ptr       <= '0;
      fill_cnt  <= '0;
    end else begin
      state <= state_nxt;
      if (ev_claim) begin
        orig_stat <= mem_rdata;
        fill_cnt  <= '0;
      end
      if (state == ST_PHI) ptr[31:16] <= mem_rdata;
      if (state == ST_PLO) ptr[15:0]  <= mem_rdata;
      if (ev_store) fill_cnt <= cnt_nxt;
      if (ev_stat_wr) desc_ofs <= orig_stat[15-SB_WRAP] ? '0 : desc_ofs + STRIDE;
    end
  end
endmodule

// File: rtl/uart_rxdesc_chk.sv
module uart_rxdesc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic [1:0]  mem_be,
  input logic [15:0] mem_wdata,
  input logic [15:0] max_len,
  input logic [15:0] fill_cnt,
  input logic        ev_store,
  input logic        store_err,
  input logic        ev_cnt_wr,
  input logic        ev_stat_wr,
  input logic        buf_done,
  input logic        busy_evt
);
  p_byte_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_store |-> (mem_req && mem_we && $countones(mem_be) == 1));

  p_store_below_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_store |-> (fill_cnt < max_len));

  p_count_then_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cnt_wr |=> ev_stat_wr);

  p_err_char_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_store && store_err) |=> ev_cnt_wr);

  p_status_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stat_wr |-> (!mem_wdata[15] && !mem_wdata[2]));

  p_done_on_close_r12: assert property (@(posedge clk) disable iff (!rst_n)
    buf_done |-> (ev_stat_wr && mem_we));

  p_drop_no_write_r13: assert property (@(posedge clk) disable iff (!rst_n)
    busy_evt |-> !(mem_req && mem_we));
endmodule

bind uart_rxdesc_engine uart_rxdesc_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_be     (mem_be),
  .mem_wdata  (mem_wdata),
  .max_len    (max_len),
  .fill_cnt   (fill_cnt),
  .ev_store   (ev_store),
  .store_err  (store_err),
  .ev_cnt_wr  (ev_cnt_wr),
  .ev_stat_wr (ev_stat_wr),
  .buf_done   (buf_done),
  .busy_evt   (busy_evt)
);

// File: tb/uart_rxdesc_engine_tb_top.sv
`timescale 1ns/1ps
module uart_rxdesc_engine_tb_top;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chr_valid = 1'b0;
  logic [7:0]    chr_data = '0;
  logic          chr_frame_err = 1'b0;
  logic          chr_parity_err = 1'b0;
  logic          chr_overrun = 1'b0;
  logic          carrier_ok = 1'b1;
  logic [AW-1:0] tbl_base = 16'd16;
  logic [15:0]   max_len = 16'd4;
  logic          mem_req, mem_we, buf_done, busy_evt;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_be;
  logic [15:0]   mem_wdata;
  logic [15:0]   mem_rdata = '0;

  logic [15:0] mem [0:511];
  int vectors = 0;
  int errors  = 0;
  int busy_n  = 0;
  int done_n  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  uart_rxdesc_engine #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_data(chr_data),
    .chr_frame_err(chr_frame_err), .chr_parity_err(chr_parity_err),
    .chr_overrun(chr_overrun), .carrier_ok(carrier_ok), .tbl_base(tbl_base),
    .max_len(max_len), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .buf_done(buf_done), .busy_evt(busy_evt)
  );

  // memory model: read data one cycle later, writes at once
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        if (mem_be[1]) mem[mem_addr[8:0]][15:8] <= mem_wdata[15:8];
        if (mem_be[0]) mem[mem_addr[8:0]][7:0]  <= mem_wdata[7:0];
      end else begin
        mem_rdata <= mem[mem_addr[8:0]];
      end
    end
  end

  always @(negedge clk) begin
    if (busy_evt) busy_n++;
    if (buf_done) done_n++;
  end

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic fr, input logic pe);
    @(negedge clk);
    chr_valid = 1'b1; chr_data = d; chr_frame_err = fr; chr_parity_err = pe;
    @(negedge clk);
    chr_valid = 1'b0; chr_frame_err = 1'b0; chr_parity_err = 1'b0;
    idle(14);
  endtask

  task automatic set_desc(input int w, input logic [15:0] st, input logic [31:0] p);
    mem[w] = st; mem[w+1] = 16'h0000; mem[w+2] = p[31:16]; mem[w+3] = p[15:0];
  endtask

  task automatic t_reset;
    int reqs = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (mem_req) reqs++;
    end
    check("R1 no request after reset", reqs, 0);
    check("R1 buf_done low", buf_done, 0);
    check("R1 busy_evt low", busy_evt, 0);
  endtask

  task automatic t_plain_fill;
    send(8'h11, 0, 0); send(8'h22, 0, 0); send(8'h33, 0, 0); send(8'h44, 0, 0);
    check("R2 R3 word 128", mem[128], 16'h1122);
    check("R3 R4 word 129", mem[129], 16'h3344);
    check("R4 count at limit", mem[17], 4);
    check("R4 status clean and released", mem[16], 16'h0000);
    check("R12 no done without interrupt bit", done_n, 0);
  endtask

  task automatic t_frame_odd;
    mem[130] = 16'hEEEE; mem[131] = 16'hEEEE;
    send(8'hA1, 0, 0);
    check("R7 first byte into second descriptor", mem[130], 16'hEEA1);
    send(8'hB2, 1, 0);
    check("R3 R5 framing byte stored as last", mem[131], 16'hB2EE);
    check("R5 count", mem[21], 2);
    check("R5 framing bit in status", mem[20], 16'h1010);
    check("R12 done pulse", done_n, 1);
  endtask

  task automatic t_parity_wrap;
    send(8'h55, 0, 1);
    check("R6 R7 parity byte in next buffer", mem[144], 16'h5500);
    check("R6 count", mem[25], 1);
    check("R6 parity bit in status", mem[24], 16'h2008);
  endtask

  task automatic t_busy_then_errs;
    send(8'h66, 0, 0);
    check("R11 R13 busy pulse at table base", busy_n, 1);
    check("R13 status untouched", mem[16], 16'h0000);
    check("R13 count untouched", mem[17], 4);
    set_desc(16, 16'hC03C, 32'h0000_0140);
    mem[160] = 16'h0000; mem[161] = 16'h0000;
    send(8'h77, 0, 0);
    check("R13 index held, char stored", mem[160], 16'h7700);
    @(negedge clk) chr_overrun = 1'b1;
    @(negedge clk) chr_overrun = 1'b0;
    carrier_ok = 1'b0;
    idle(2);
    carrier_ok = 1'b1;
    send(8'h78, 0, 0); send(8'h79, 0, 0); send(8'h7A, 0, 0);
    check("R8 R9 overrun does not close", mem[161], 16'h797A);
    check("R10 R8 R9 status merge", mem[16], 16'hC023 & 16'h7FFF);
    check("R13 busy count steady", busy_n, 1);
  endtask

  task automatic t_overflow;
    set_desc(20, 16'h8000, 32'h0000_0180);
    mem[192] = 16'h0000;
    max_len = 16'd2;
    @(negedge clk);
    chr_valid = 1'b1; chr_data = 8'h91;
    @(negedge clk);
    chr_data = 8'h92;
    @(negedge clk);
    chr_valid = 1'b0;
    idle(14);
    send(8'h93, 0, 0);
    check("R8 lost char skipped", mem[192], 16'h9193);
    check("R8 count", mem[21], 2);
    check("R8 overrun bit", mem[20], 16'h0002);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 16'h0000;
    set_desc(16, 16'h8000, 32'h0000_0100);
    set_desc(20, 16'h9000, 32'h0000_0105);
    set_desc(24, 16'hA000, 32'h0000_0120);
    idle(3);
    rst_n = 1'b1;
    t_reset();
    t_plain_fill();
    t_frame_odd();
    t_parity_wrap();
    t_busy_then_errs();
    t_overflow();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule